// File: doc/BRIEF.md
# Scratchpad-Staged Memory Write Controller

This block sits in front of a small nonvolatile-style store and makes sure no byte reaches it without first passing through an eight-byte staging row. A master talks to it with byte frames on a valid/ready input stream, where `in_last` marks the final byte of a frame. Any reply comes back on a valid/ready output stream.

There are four commands. A staging write, code 0xA1, is followed by a target address and data bytes. A staging read, code 0xA2, returns the latched target address and then the eight staged bytes. A commit, code 0xA3, is followed by an address that must repeat the latched target. A memory read, code 0xA4, is followed by a start address and returns `READ_LEN` consecutive bytes. The store holds four 32-byte data pages at addresses 0x00 to 0x7F and an eight-byte register page at 0x80 to 0x87. The register byte at 0x87 is read-only. Nothing is mapped above 0x87.

A commit holds the block busy for `PROG_CYCLES` clock cycles, which models the programming time. The staged row is written into the store when that interval ends.

Top module: `scratch_mem_ctrl`

## Requirements
- R1: After reset, `busy` and `out_valid` are low and `in_ready` is high. Every mapped memory byte reads 0x00, and the staged bytes and latched target read 0x00.
- R2: A staging write frame is [0xA1, addr, d0, d1, ...]. It latches addr as the target and stores d0 at row offset addr[2:0], d1 at the next offset, and so on. Data bytes past offset 7 are dropped. A staging read frame is the single byte 0xA2 and returns nine bytes: the target, then staged bytes at offsets 0 to 7.
- R3: A staging write leaves main memory unchanged.
- R4: A commit frame is [0xA3, addr] with `in_last` on addr. If a staging write has occurred since the last commit and addr equals the latched target, the eight staged bytes go to the row at addr with bits [2:0] cleared. The store changes only when programming ends.
- R5: A commit whose address differs from the target is ignored: `busy` stays low and memory is unchanged. A second commit with no staging write in between is also ignored.
- R6: An accepted commit holds `busy` high for exactly `PROG_CYCLES` cycles, starting with the clock edge that accepts its address byte. `in_ready` is low whenever `busy` is high.
- R7: Commits to the register page update bytes 0x80 to 0x86. Byte 0x87 keeps its value.
- R8: Memory reads at addresses 0x88 and above return 0xFF. A commit to such a row changes no readable byte.
- R9: A memory read frame is [0xA4, addr] with `in_last` on addr. It returns the bytes at addr to addr+`READ_LEN`-1 in order, crossing row and page boundaries.
- R10: A frame with an unknown command code, or a commit or memory-read frame whose address byte lacks `in_last`, is dropped up to its last byte. It has no effect.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts an input byte |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte ends the frame |
| out_valid | output | 1 | Reply byte valid |
| out_ready | input | 1 | Master takes the reply byte |
| out_data | output | 8 | Reply byte |
| busy | output | 1 | Commit programming in progress |

## Verification
The hardest case to reach is a commit that must be refused even though the staged data are good. This happens when the address byte is off by one from the target, or when the same commit is issued again after an accepted one. The stimulus first stages a row, then sends the wrong or repeated commit. It then confirms at the ports that `busy` never rises and that a memory read returns the old contents. A malformed commit frame, one with bytes after its address, is driven the same way. The read-only register byte is reached by staging a full register-page row and committing it.

// File: rtl/scratch_mem_ctrl.sv
module scratch_mem_ctrl #(
  parameter int PAGE_BYTES  = 32,
  parameter int NUM_PAGES   = 4,
  parameter int REG_BYTES   = 8,
  parameter int ROW_BYTES   = 8,
  parameter int RO_REG_IDX  = 7,
  parameter int PROG_CYCLES = 40,
  parameter int READ_LEN    = 8,
  parameter int ADDR_W      = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       busy
);
  localparam int DATA_BYTES = PAGE_BYTES * NUM_PAGES;
  localparam int TOTAL      = DATA_BYTES + REG_BYTES;
  localparam int RO_ADDR    = DATA_BYTES + RO_REG_IDX;
  localparam int ROW_LG     = $clog2(ROW_BYTES);
  localparam int MAXLEN     = (ROW_BYTES + 1 > READ_LEN) ? ROW_BYTES + 1 : READ_LEN;
  localparam int IW         = $clog2(MAXLEN + 1);
  localparam int CW         = $clog2(PROG_CYCLES + 1);
  localparam logic [7:0] CMD_WR = 8'hA1;
  localparam logic [7:0] CMD_RS = 8'hA2;
  localparam logic [7:0] CMD_CP = 8'hA3;
  localparam logic [7:0] CMD_RM = 8'hA4;

  typedef enum logic [2:0] {S_CMD, S_ADDR, S_WDAT, S_SKIP, S_SEND, S_PROG} st_t;

  st_t st;
  logic [7:0]        cmd;
  logic [ADDR_W-1:0] ta;
  logic              armed;
  logic [ROW_LG:0]   wofs;
  logic [ADDR_W:0]   rptr;
  logic [IW-1:0]     sidx;
  logic [CW-1:0]     pcnt;
  logic [7:0]        sp  [ROW_BYTES];
  logic [7:0]        mem [TOTAL];
  logic              commit, send_last;
  logic [ADDR_W:0]   raddr;
  logic [7:0]        rbyte;

  assign in_ready  = (st == S_CMD) || (st == S_ADDR) || (st == S_WDAT) || (st == S_SKIP);
  assign out_valid = (st == S_SEND);
  assign busy      = (st == S_PROG);
  assign commit    = busy && (pcnt == '0);
  assign send_last = (cmd == CMD_RS) ? (sidx == IW'(ROW_BYTES)) : (sidx == IW'(READ_LEN - 1));
  assign raddr     = rptr + (ADDR_W+1)'(sidx);

  always_comb begin
    rbyte = 8'hFF;
    for (int a = 0; a < TOTAL; a++)
      if (raddr == (ADDR_W+1)'(a)) rbyte = mem[a];
  end

  always_comb begin
    if (cmd == CMD_RS)
      out_data = (sidx == '0) ? 8'(ta) : sp[ROW_LG'(sidx - 1'b1)];
    else
      out_data = rbyte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_CMD; cmd <= '0; ta <= '0; armed <= 1'b0;
      wofs <= '0; rptr <= '0; sidx <= '0; pcnt <= '0;
      for (int i = 0; i < ROW_BYTES; i++) sp[i] <= '0;
    end else begin
      case (st)
        S_CMD: if (in_valid) begin
          cmd  <= in_data;
          sidx <= '0;
          if (in_last) st <= (in_data == CMD_RS) ? S_SEND : S_CMD;
          else st <= (in_data == CMD_WR || in_data == CMD_CP || in_data == CMD_RM) ? S_ADDR : S_SKIP;
        end
        S_ADDR: if (in_valid) begin
          if (cmd == CMD_WR) begin
            ta    <= ADDR_W'(in_data);
            armed <= 1'b1;
            wofs  <= {1'b0, in_data[ROW_LG-1:0]};
            st    <= in_last ? S_CMD : S_WDAT;
          end else if (cmd == CMD_CP) begin
            if (!in_last) st <= S_SKIP;
            else if (armed && ADDR_W'(in_data) == ta) begin
              armed <= 1'b0;
              pcnt  <= CW'(PROG_CYCLES - 1);
              st    <= S_PROG;
            end else st <= S_CMD;
          end else begin
            rptr <= (ADDR_W+1)'(in_data);
            st   <= in_last ? S_SEND : S_SKIP;
          end
        end
        S_WDAT: if (in_valid) begin
          if (!wofs[ROW_LG]) begin
            sp[wofs[ROW_LG-1:0]] <= in_data;
            wofs <= wofs + 1'b1;
          end
          if (in_last) st <= S_CMD;
        end
        S_SKIP: if (in_valid && in_last) st <= S_CMD;
        S_SEND: if (out_ready) begin
          sidx <= sidx + 1'b1;
          if (send_last) st <= S_CMD;
        end
        S_PROG: if (pcnt == '0) st <= S_CMD; else pcnt <= pcnt - 1'b1;
        default: st <= S_CMD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < TOTAL; a++) mem[a] <= '0;
    end else if (commit) begin
      for (int a = 0; a < TOTAL; a++)
        if (a[ADDR_W-1:ROW_LG] == ta[ADDR_W-1:ROW_LG] && a != RO_ADDR)
          mem[a] <= sp[a[ROW_LG-1:0]];
    end
  end

  logic [CW:0] brun;
  always_ff @(posedge clk) begin
    if (!rst_n) brun <= '0;
    else brun <= busy ? brun + 1'b1 : '0;
  end

  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> brun == (CW+1)'(PROG_CYCLES));
  p_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
  p_ro_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mem[RO_ADDR]));
  p_mismatch_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR && cmd == CMD_CP && in_valid && in_last && ADDR_W'(in_data) != ta) |=> !busy);
  p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/test_scratch_mem_ctrl.sv
`timescale 1ns/1ps
module test_scratch_mem_ctrl;
  localparam int TOTAL = 136;
  localparam int PROG  = 40;
  localparam int RLEN  = 8;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, out_ready = 0;
  logic [7:0] in_data = 0;
  logic in_ready, out_valid, busy;
  logic [7:0] out_data;
  int checks = 0, fails = 0;
  logic [7:0] model [TOTAL];
  logic [7:0] spm [8];
  logic [7:0] tam;

  always #2.5 clk = ~clk;

  scratch_mem_ctrl i_scratch_mem_ctrl (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .busy(busy));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b, logic last);
    @(negedge clk); in_valid = 1; in_data = b; in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk); in_valid = 0; in_last = 0;
  endtask

  task automatic recv(output logic [7:0] d);
    out_ready = 1;
    while (!out_valid) @(negedge clk);
    d = out_data;
    @(negedge clk); out_ready = 0;
  endtask

  function automatic logic [7:0] exp_mem(int a);
    return (a < TOTAL) ? model[a] : 8'hFF;
  endfunction

  task automatic read_mem(logic [7:0] a, string req);
    logic [7:0] d;
    send(8'hA4, 0); send(a, 1);
    for (int i = 0; i < RLEN; i++) begin recv(d); check(req, d, exp_mem(a + i)); end
  endtask

  task automatic stage(logic [7:0] a, int n, logic [7:0] seed);
    send(8'hA1, 0); send(a, n == 0);
    tam = a;
    for (int i = 0; i < n; i++) begin
      send(seed + 8'(i), i == n - 1);
      if (a[2:0] + i < 8) spm[a[2:0] + i] = seed + 8'(i);
    end
  endtask

  task automatic read_sp(string req);
    logic [7:0] d;
    send(8'hA2, 1);
    recv(d); check(req, d, tam);
    for (int i = 0; i < 8; i++) begin recv(d); check(req, d, spm[i]); end
  endtask

  task automatic copy_ok(logic [7:0] a, string req);
    int n = 0;
    send(8'hA3, 0); send(a, 1);
    while (busy) begin n++; @(negedge clk); end
    check(req, n, PROG);
    for (int i = 0; i < 8; i++)
      if ((a & 8'hF8) + i < TOTAL && (a & 8'hF8) + i != 135) model[(a & 8'hF8) + i] = spm[i];
  endtask

  task automatic copy_refused(logic [7:0] a, string req);
    send(8'hA3, 0); send(a, 1);
    check(req, busy, 0);
    @(negedge clk); check(req, busy, 0);
  endtask

  task automatic t_reset;
    check("R1 busy", busy, 0); check("R1 in_ready", in_ready, 1); check("R1 out_valid", out_valid, 0);
    read_mem(8'h00, "R1 mem");
    read_sp("R1 scratch");
  endtask

  task automatic t_stage;
    stage(8'h13, 6, 8'h40);
    read_sp("R2 readback");
    read_mem(8'h10, "R3 untouched");
  endtask

  task automatic t_commit;
    copy_ok(8'h13, "R6 busy length");
    read_mem(8'h10, "R4 committed row");
  endtask

  task automatic t_refuse;
    stage(8'h20, 8, 8'h70);
    copy_refused(8'h21, "R5 mismatch");
    read_mem(8'h20, "R5 mem unchanged");
    copy_ok(8'h20, "R6 busy length");
    copy_refused(8'h20, "R5 repeat");
    read_mem(8'h20, "R4 second row");
  endtask

  task automatic t_regpage;
    stage(8'h80, 8, 8'hC0);
    copy_ok(8'h80, "R6 busy length");
    read_mem(8'h80, "R7 register page");
    check("R7 ro byte", model[135], 8'h00);
  endtask

  task automatic t_beyond;
    read_mem(8'h88, "R8 unmapped");
    stage(8'h90, 8, 8'h11);
    copy_ok(8'h90, "R8 commit unmapped");
    read_mem(8'h90, "R8 still ones");
    read_mem(8'h84, "R8 edge");
  endtask

  task automatic t_cross;
    stage(8'h38, 8, 8'h90);
    copy_ok(8'h38, "R6 busy length");
    read_mem(8'h1C, "R9 cross row");
    read_mem(8'h3C, "R9 cross page");
  endtask

  task automatic t_junk;
    stage(8'h48, 8, 8'h33);
    send(8'h77, 0); send(8'h01, 0); send(8'hA1, 1);
    send(8'hA3, 0); send(8'h48, 0); send(8'hEE, 1);
    check("R10 no commit", busy, 0);
    send(8'hA4, 0); send(8'h48, 0); send(8'h00, 1);
    @(negedge clk); check("R10 no reply", out_valid, 0);
    read_sp("R10 scratch intact");
    read_mem(8'h48, "R10 mem intact");
  endtask

  task automatic t_stall;
    logic [7:0] d;
    send(8'hA2, 1);
    repeat (4) @(negedge clk);
    check("R11 valid held", out_valid, 1); check("R11 data held", out_data, tam);
    recv(d); check("R11 first", d, tam);
    for (int i = 0; i < 8; i++) begin recv(d); check("R11 rest", d, spm[i]); end
  endtask

  initial begin
    for (int i = 0; i < TOTAL; i++) model[i] = 0;
    for (int i = 0; i < 8; i++) spm[i] = 0;
    tam = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_stage; t_commit; t_refuse; t_regpage; t_beyond; t_cross; t_junk; t_stall;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule